// File: doc/BRIEF.md
# Hardware Cursor and Crosshair Overlay

This block generates a small overlay that sits on top of a raster display. On each pixel clock it receives the current column and scanline counters and the overlay settings. It returns two cursor plane bits and a crosshair bit for that pixel. The cursor is a 64 by 64 image with two bit planes. It is held in an internal pattern store that is written one 16-bit word at a time. The crosshair is a pair of lines through the cursor position. Their thickness can be selected, and they are clipped to a rectangular window. The cursor planes and the crosshair are merged by OR or by XOR.

Position and window coordinates are 12-bit values measured from the sync edges. Software adds the blanking offsets itself, so the block compares the coordinates directly against the raw counters. One pixel is handled per clock. Every output is registered, so each result appears one clock after the counters that produced it.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is asserted, all three outputs are 0.
- R2: The cursor covers columns curs_x to curs_x+63 and rows curs_y to curs_y+63. For a pixel with offsets (dx, dy) inside it, the block reads pattern word dy*8 + dx/8 and uses bit 7-(dx mod 8) of each byte. The upper byte [15:8] is plane_hi and the lower byte [7:0] is plane_lo. Outside the cursor, both cursor bits are 0.
- R3: Bit 6 of cmd enables the cursor. When it is clear, both plane outputs carry only the crosshair term.
- R4: Bit 5 of cmd enables the crosshair. When it is clear, xhair is 0. With bits 6 and 5 both clear, all outputs are 0.
- R5: Bits [1:0] of cmd hold a value k. A pixel is on the crosshair when its column is within k of curs_x or its row is within k of curs_y. This gives a line width of 1, 3, 5 or 7.
- R6: The crosshair is drawn only where win_x <= column < win_x+win_w and win_y <= row < win_y+win_h. A zero width or zero height draws no crosshair.
- R7: Bit 4 of cmd selects the merge. With the bit set, each plane output is the cursor bit OR the crosshair bit. With the bit clear, it is the cursor bit XOR the crosshair bit.
- R8: The outputs show the result for the counters and settings that were present one clock edge earlier.
- R9: When pat_we is high at a clock edge, pat_wdata is stored in pattern word pat_addr. Later cursor pixels that use that word take their bits from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| pat_we | input | 1 | Pattern word write strobe |
| pat_addr | input | 9 | Pattern word address |
| pat_wdata | input | 16 | Pattern word: upper byte is plane_hi, lower byte is plane_lo |
| cmd | input | 8 | Settings: bit 6 cursor enable, bit 5 crosshair enable, bit 4 OR merge, bits [1:0] thickness |
| curs_x | input | 12 | Cursor column, relative to sync |
| curs_y | input | 12 | Cursor row, relative to sync |
| win_x | input | 12 | Crosshair window left column |
| win_y | input | 12 | Crosshair window top row |
| win_w | input | 12 | Crosshair window width |
| win_h | input | 12 | Crosshair window height |
| pix_x | input | 12 | Current column counter |
| pix_y | input | 12 | Current scanline counter |
| plane_hi | output | 1 | Merged upper-plane overlay bit |
| plane_lo | output | 1 | Merged lower-plane overlay bit |
| xhair | output | 1 | Crosshair bit |

## Verification
All three outputs are due exactly one clock edge after the counters and settings are applied. The bench changes inputs on the falling edge and checks, on the next falling edge, the result for the inputs it drove one edge earlier. A new pixel is presented on every cycle, so this pipelined check also covers the single-cycle latency. Pattern writes take effect at the edge where they are issued. The bench finishes loading all words before the first sweep reads any of them.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int CW  = 12,
  parameter int SZ  = 64,
  parameter int GRP = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pat_we,
  input  logic [$clog2(SZ*SZ/GRP)-1:0]  pat_addr,
  input  logic [2*GRP-1:0]              pat_wdata,
  input  logic [7:0]                    cmd,
  input  logic [CW-1:0]                 curs_x,
  input  logic [CW-1:0]                 curs_y,
  input  logic [CW-1:0]                 win_x,
  input  logic [CW-1:0]                 win_y,
  input  logic [CW-1:0]                 win_w,
  input  logic [CW-1:0]                 win_h,
  input  logic [CW-1:0]                 pix_x,
  input  logic [CW-1:0]                 pix_y,
  output logic                          plane_hi,
  output logic                          plane_lo,
  output logic                          xhair
);
  localparam int DEPTH = SZ * SZ / GRP;
  localparam int AW    = $clog2(DEPTH);
  localparam int OW    = $clog2(SZ);
  localparam int BW    = $clog2(GRP);

  logic [2*GRP-1:0] pat_mem [DEPTH];

  always_ff @(posedge clk)
    if (pat_we) pat_mem[pat_addr] <= pat_wdata;

  logic [CW:0] dx, dy, adx, ady;
  assign dx  = {1'b0, pix_x} - {1'b0, curs_x};
  assign dy  = {1'b0, pix_y} - {1'b0, curs_y};
  assign adx = dx[CW] ? -dx : dx;
  assign ady = dy[CW] ? -dy : dy;

  logic in_curs;
  assign in_curs = !dx[CW] && !dy[CW] && (dx < (CW+1)'(SZ)) && (dy < (CW+1)'(SZ));

  logic [AW-1:0]    rd_addr;
  logic [2*GRP-1:0] rd_word;
  logic [BW-1:0]    bsel;
  assign rd_addr = {dy[OW-1:0], dx[OW-1:BW]};
  assign rd_word = pat_mem[rd_addr];
  assign bsel    = BW'(GRP-1) - dx[BW-1:0];

  logic c_hi, c_lo;
  assign c_hi = cmd[6] && in_curs && rd_word[GRP + 32'(bsel)];
  assign c_lo = cmd[6] && in_curs && rd_word[bsel];

  logic [CW:0] thick;
  assign thick = (CW+1)'(cmd[1:0]);

  logic in_win;
  assign in_win = (pix_x >= win_x) && ({1'b0, pix_x} < {1'b0, win_x} + {1'b0, win_w}) &&
                  (pix_y >= win_y) && ({1'b0, pix_y} < {1'b0, win_y} + {1'b0, win_h});

  logic xh;
  assign xh = cmd[5] && in_win && ((adx <= thick) || (ady <= thick));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      plane_hi <= 1'b0;
      plane_lo <= 1'b0;
      xhair    <= 1'b0;
    end else begin
      plane_hi <= cmd[4] ? (c_hi | xh) : (c_hi ^ xh);
      plane_lo <= cmd[4] ? (c_lo | xh) : (c_lo ^ xh);
      xhair    <= xh;
    end

  // R4
  both_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd[6] && !cmd[5]) |=> (!plane_hi && !plane_lo && !xhair));

  // R4
  xh_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd[5] |=> !xhair);

  // R3
  curs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd[6] |=> (plane_hi == xhair && plane_lo == xhair));

  // R6
  empty_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_w == '0 || win_h == '0) |=> !xhair);

  // R7
  or_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd[4] |=> (!xhair || (plane_hi && plane_lo)));
endmodule

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pat_we = 1'b0;
  logic [8:0] pat_addr = '0;
  logic [15:0] pat_wdata = '0;
  logic [7:0] cmd = '0;
  logic [11:0] curs_x = '0, curs_y = '0, win_x = '0, win_y = '0, win_w = '0, win_h = '0;
  logic [11:0] pix_x = '0, pix_y = '0;
  logic plane_hi, plane_lo, xhair;

  always #4 clk = ~clk;

  cursor_overlay dut (.*);

  logic [15:0] pat [512];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [15:0] pat_val(int a);
    return 16'((a * 37) ^ (a << 7) ^ 16'h5A3C);
  endfunction

  function automatic void model(int px, int py, output bit h, output bit l, output bit x);
    int dx, dy, t, adx, ady, b;
    bit inc, m, d, inw, xh;
    logic [15:0] w;
    dx = px - int'(curs_x); dy = py - int'(curs_y);
    adx = dx < 0 ? -dx : dx; ady = dy < 0 ? -dy : dy;
    inc = dx >= 0 && dx < 64 && dy >= 0 && dy < 64;
    m = 0; d = 0;
    if (inc) begin
      w = pat[dy * 8 + dx / 8];
      b = 7 - dx % 8;
      m = w[8 + b]; d = w[b];
    end
    m = m && cmd[6]; d = d && cmd[6];
    t = int'(cmd[1:0]);
    inw = px >= int'(win_x) && px < int'(win_x) + int'(win_w) &&
          py >= int'(win_y) && py < int'(win_y) + int'(win_h);
    xh = cmd[5] && inw && (adx <= t || ady <= t);
    h = cmd[4] ? (m | xh) : (m ^ xh);
    l = cmd[4] ? (d | xh) : (d ^ xh);
    x = xh;
  endfunction

  task automatic sweep(string tag, logic [7:0] c, int wx, int wy, int ww, int wh);
    bit eh, el, ex, pend;
    pend = 0;
    for (int y = 44; y <= 118; y++)
      for (int x = 90; x <= 170; x++) begin
        @(negedge clk);
        if (pend) begin
          checks++;
          if ({plane_hi, plane_lo, xhair} !== {eh, el, ex}) begin
            fails++;
            $display("FAIL %s R8 pixel got %b%b%b expected %b%b%b", tag, plane_hi, plane_lo, xhair, eh, el, ex);
          end
        end
        cmd = c; curs_x = 12'd100; curs_y = 12'd50;
        win_x = 12'(wx); win_y = 12'(wy); win_w = 12'(ww); win_h = 12'(wh);
        pix_x = 12'(x); pix_y = 12'(y);
        model(x, y, eh, el, ex);
        pend = 1;
      end
    @(negedge clk);
    checks++;
    if ({plane_hi, plane_lo, xhair} !== {eh, el, ex}) begin
      fails++;
      $display("FAIL %s R8 last pixel got %b%b%b expected %b%b%b", tag, plane_hi, plane_lo, xhair, eh, el, ex);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cmd = 8'h70; win_w = 12'd500; win_h = 12'd500; pix_x = 12'd100; pix_y = 12'd50;
    repeat (3) @(negedge clk);
    checks++;
    if ({plane_hi, plane_lo, xhair} !== 3'b000) begin
      fails++;
      $display("FAIL R1 reset got %b%b%b expected 000", plane_hi, plane_lo, xhair);
    end
    rst_n = 1'b1;
    cmd = 8'h00;
    for (int a = 0; a < 512; a++) begin
      @(negedge clk);
      pat_we = 1'b1; pat_addr = 9'(a); pat_wdata = pat_val(a); pat[a] = pat_val(a);
    end
    @(negedge clk);
    pat_we = 1'b0;
    sweep("R2 R9 cursor only", 8'h40, 0, 0, 4000, 4000);
    sweep("R5 R7 xor thick3", 8'h61, 0, 0, 4000, 4000);
    sweep("R5 R7 or thick5", 8'h72, 0, 0, 4000, 4000);
    sweep("R3 R5 crosshair only thick7", 8'h23, 0, 0, 4000, 4000);
    sweep("R4 all off", 8'h13, 0, 0, 4000, 4000);
    sweep("R6 zero window", 8'h71, 0, 0, 0, 0);
    sweep("R6 clipped window", 8'h73, 120, 60, 30, 40);
    sweep("R6 zero height", 8'h60, 90, 40, 50, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule